// File: doc/BRIEF.md
# Quarter-Wave Sine Numerically Controlled Oscillator

The block is a numerically controlled oscillator. It produces a stream of signed sine amplitude samples whose frequency is set by a programmable step word. A phase register adds the active step word on every clock and wraps modulo 2^PHASE_W, so its carry out is lost. The output frequency is therefore step × f_clk / 2^PHASE_W. Only the upper PHASE_BITS of the phase are used for the lookup; the lower bits are dropped. These bits are folded onto a table that holds one quarter of a sine cycle, and mirror and sign logic rebuild the full waveform from it. The table is computed when the design is elaborated.

A new step word is written one byte at a time into a holding register. A separate commit strobe then copies the whole holding register into the active step register in a single cycle. The phase register is never cleared or reloaded by this operation, so a frequency change is phase-continuous: the old step is applied up to and including the commit edge, and the new step from the next edge on. A sample leaves the block two clocks after the phase value it was computed from.

Top module: `nco_quarter_sine`

## Requirements
- R1: While rst_ni is low, phase_o, sample_o and valid_o are zero, and both the active step word and the holding word are cleared. A committed word that was never written therefore gives a step of zero.
- R2: On every rising clock edge outside reset, phase_o becomes (phase_o + active step) modulo 2^PHASE_W.
- R3: When byte_we_i is high at an edge, byte_i is stored into bits [8*byte_idx_i+7 : 8*byte_idx_i] of the holding word. Byte index 0 is the least significant byte. The write has no effect on the phase step until a commit.
- R4: When commit_i is high at an edge, the holding word becomes the active step. The phase update made at that same edge still uses the old step, and the phase register is neither reset nor reloaded.
- R5: When byte_we_i and commit_i are high at the same edge, the commit takes the holding word as it stood before that edge's byte write.
- R6: Let k be the top PHASE_BITS of the phase value two edges earlier. sample_o is then the two's complement value round((2^(SAMPLE_W-1)-1) × sin(2π(k+0.5)/2^PHASE_BITS)), which lies within ±1 LSB of the real sine. Its magnitude never exceeds 2^(SAMPLE_W-1)-1.
- R7: Bit PHASE_BITS-1 of k selects the negative half cycle: sample_o is negative exactly when that bit was 1. Bit PHASE_BITS-2 selects mirrored addressing of the quarter table, where the address becomes 2^(PHASE_BITS-2)-1-addr.
- R8: valid_o is low for the first two rising edges after reset is released and stays high from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Step word byte to store |
| byte_idx_i | input | $clog2(PHASE_W/8) | Byte lane of the holding word, 0 = least significant |
| byte_we_i | input | 1 | Store byte_i into the selected lane |
| commit_i | input | 1 | Copy the holding word into the active step register |
| phase_o | output | PHASE_W | Current phase register |
| sample_o | output | SAMPLE_W | Signed sine sample |
| valid_o | output | 1 | sample_o holds a computed value |

## Verification
A wrong step or a wrong commit shows on phase_o one clock later, and from then on every cycle differs from the model, because the error accumulates. A fault in the fold logic appears two clocks later as a sample that misses the real sine by more than one LSB, or that has the wrong sign in one quadrant only. For that reason the sample is compared on every cycle, across step words that sweep all four quadrants. A phase discontinuity at a commit shows as a single-cycle jump in phase_o that differs from the old step.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic neg;
    logic mirror;
  } quad_t;

  function automatic quad_t quad_decode(input logic [1:0] q);
    quad_t r;
    r.neg    = q[1];
    r.mirror = q[0];
    return r;
  endfunction
endpackage

// File: rtl/nco_tune_regs.sv
module nco_tune_regs #(
  parameter int PHASE_W = 32,
  localparam int NBYTES = PHASE_W / 8,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         byte_i,
  input  logic [IDX_W-1:0]   byte_idx_i,
  input  logic               byte_we_i,
  input  logic               commit_i,
  output logic [PHASE_W-1:0] hold_o,
  output logic [PHASE_W-1:0] delta_o
);
  logic [PHASE_W-1:0] hold_q, delta_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q[8*b +: 8] <= '0;
      else if (byte_we_i && byte_idx_i == IDX_W'(b)) hold_q[8*b +: 8] <= byte_i;
    end
  end

  // commit sees hold_q before this edge's byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       delta_q <= '0;
    else if (commit_i) delta_q <= hold_q;
  end

  assign hold_o  = hold_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] delta_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + delta_i;  // carry dropped: wraps
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 15,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);
  localparam real PI  = 3.14159265358979323846;
  localparam real AMP = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] tab_w [DEPTH];

  // sampled at mid-step so mirrored addressing is exactly symmetric
  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam real ANG = PI / 2.0 * (real'(i) + 0.5) / real'(DEPTH);
    localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
    assign tab_w[i] = MAG_W'(VAL);
  end

  assign mag_o = tab_w[addr_i];
endmodule

// File: rtl/nco_fold_pipe.sv
module nco_fold_pipe
  import nco_pkg::*;
#(
  parameter int PHASE_BITS = 10,
  parameter int SAMPLE_W   = 16,
  localparam int ADDR_W    = PHASE_BITS - 2,
  localparam int MAG_W     = SAMPLE_W - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PHASE_BITS-1:0] phase_top_i,
  output logic [ADDR_W-1:0]     rom_addr_o,
  input  logic [MAG_W-1:0]      rom_mag_i,
  output logic [SAMPLE_W-1:0]   sample_o,
  output logic                  valid_o
);
  quad_t            quad;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic [1:0]       vld_q;
  logic [SAMPLE_W-1:0] sample_q;

  assign quad       = quad_decode(phase_top_i[PHASE_BITS-1 -: 2]);
  assign rom_addr_o = quad.mirror ? ~phase_top_i[ADDR_W-1:0] : phase_top_i[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q    <= '0;
      neg_q    <= 1'b0;
      sample_q <= '0;
      vld_q    <= '0;
    end else begin
      mag_q    <= rom_mag_i;
      neg_q    <= quad.neg;
      sample_q <= neg_q ? -{1'b0, mag_q} : {1'b0, mag_q};
      vld_q    <= {vld_q[0], 1'b1};
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = vld_q[1];
endmodule

// File: rtl/nco_quarter_sine.sv
module nco_quarter_sine #(
  parameter int PHASE_W    = 32,
  parameter int PHASE_BITS = 10,
  parameter int SAMPLE_W   = 16,
  localparam int IDX_W     = $clog2(PHASE_W / 8)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          byte_i,
  input  logic [IDX_W-1:0]    byte_idx_i,
  input  logic                byte_we_i,
  input  logic                commit_i,
  output logic [PHASE_W-1:0]  phase_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  localparam int ADDR_W = PHASE_BITS - 2;
  localparam int MAG_W  = SAMPLE_W - 1;

  logic [PHASE_W-1:0] hold_w, delta_w, phase_w;
  logic [ADDR_W-1:0]  rom_addr_w;
  logic [MAG_W-1:0]   rom_mag_w;

  nco_tune_regs #(.PHASE_W(PHASE_W)) u_tune (
    .clk_i, .rst_ni, .byte_i, .byte_idx_i, .byte_we_i, .commit_i,
    .hold_o(hold_w), .delta_o(delta_w)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i, .rst_ni, .delta_i(delta_w), .phase_o(phase_w)
  );

  nco_sine_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .addr_i(rom_addr_w), .mag_o(rom_mag_w)
  );

  nco_fold_pipe #(.PHASE_BITS(PHASE_BITS), .SAMPLE_W(SAMPLE_W)) u_fold (
    .clk_i, .rst_ni,
    .phase_top_i(phase_w[PHASE_W-1 -: PHASE_BITS]),
    .rom_addr_o(rom_addr_w), .rom_mag_i(rom_mag_w),
    .sample_o, .valid_o
  );

  assign phase_o = phase_w;
endmodule

// File: rtl/nco_quarter_sine_chk.sv
module nco_quarter_sine_chk #(
  parameter int PHASE_W    = 32,
  parameter int SAMPLE_W   = 16,
  localparam int IDX_W     = $clog2(PHASE_W / 8)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                byte_we_i,
  input logic                commit_i,
  input logic [PHASE_W-1:0]  hold_w,
  input logic [PHASE_W-1:0]  delta_w,
  input logic [PHASE_W-1:0]  phase_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                valid_o
);
  initial begin
    p_width_cfg: assert (PHASE_W % 8 == 0 && PHASE_W >= 24 && PHASE_W <= 48)
      else $error("step word width out of range");
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (phase_o == '0 && !valid_o && delta_w == '0));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == $past(phase_o) + $past(delta_w));

  p_hold_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_we_i) |-> hold_w == $past(hold_w));

  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit_i) |-> delta_w == $past(hold_w));

  p_delta_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(delta_w));

  p_mag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != {1'b1, {(SAMPLE_W-1){1'b0}}});

  p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o[SAMPLE_W-1] == $past(phase_o[PHASE_W-1], 2));

  p_valid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o) |-> valid_o);
endmodule

bind nco_quarter_sine nco_quarter_sine_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_we_i(byte_we_i), .commit_i(commit_i),
  .hold_w(hold_w), .delta_w(delta_w), .phase_o(phase_o),
  .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/nco_quarter_sine_tb.sv
module nco_quarter_sine_tb_top;
  localparam int  PW = 32;
  localparam int  PB = 10;
  localparam int  SW = 16;
  localparam real PI = 3.14159265358979323846;
  localparam real AMP = 32767.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    byte_v = '0;
  logic [1:0]    idx_v = '0;
  logic          we_v = 1'b0;
  logic          cm_v = 1'b0;
  logic [PW-1:0] phase;
  logic [SW-1:0] sample;
  logic          valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [PW-1:0] ph_m, act_m, hold_m;
  logic [PW-1:0] hist[$];
  int edges;

  always #5 clk = ~clk;

  nco_quarter_sine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_v), .byte_idx_i(idx_v),
    .byte_we_i(we_v), .commit_i(cm_v), .phase_o(phase), .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [PB-1:0] k;
    real e, d;
    chk(phase == ph_m, "R2 phase", phase, ph_m);
    chk(valid == (edges >= 2), "R8 valid", valid, edges >= 2);
    if (edges >= 2) begin
      k = hist[hist.size()-3][PW-1 -: PB];
      e = AMP * $sin(2.0 * PI * (real'(k) + 0.5) / real'(1 << PB));
      d = real'($signed(sample)) - e;
      chk(d <= 1.0 && d >= -1.0, "R6 sine", $signed(sample), $rtoi(e));
      chk(sample[SW-1] == k[PB-1], "R7 sign", sample[SW-1], k[PB-1]);
    end
  endtask

  task automatic tick(input bit we, input logic [1:0] idx, input logic [7:0] b, input bit cm);
    logic [PW-1:0] nxt;
    we_v = we; idx_v = idx; byte_v = b; cm_v = cm;
    @(posedge clk);
    nxt = ph_m + act_m;
    if (cm) act_m = hold_m;
    if (we) hold_m[8*idx +: 8] = b;
    ph_m = nxt;
    hist.push_back(ph_m);
    if (hist.size() > 4) void'(hist.pop_front());
    edges++;
    @(negedge clk);
    we_v = 1'b0; cm_v = 1'b0;
    compare();
  endtask

  task automatic load(input logic [PW-1:0] w);
    for (int i = 0; i < 4; i++) tick(1'b1, 2'(i), w[8*i +: 8], 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  initial begin
    logic [PW-1:0] p0;
    ph_m = '0; act_m = '0; hold_m = '0; edges = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phase == '0, "R1 phase", phase, 0);
    chk(sample == '0, "R1 sample", sample, 0);
    chk(valid == 1'b0, "R1 valid", valid, 0);
    rst_n = 1'b1;
    hist.push_back('0);
    // R1: commit of an unwritten holding word gives zero step
    tick(1'b0, 2'd0, 8'd0, 1'b1);
    run(3);
    chk(phase == '0, "R1 zero step", phase, 0);

    // R3: bytes written without commit leave the step unchanged
    load(32'h0100_0000);
    run(4);
    chk(phase == '0, "R3 no commit", phase, 0);
    tick(1'b0, 2'd0, 8'd0, 1'b1);
    run(1100);

    // R4: mid-run commit, phase continuous
    load(32'h1234_5677);
    p0 = phase;
    tick(1'b0, 2'd0, 8'd0, 1'b1);
    chk(phase == p0 + 32'h0100_0000, "R4 old step at commit edge", phase, p0 + 32'h0100_0000);
    p0 = phase;
    tick(1'b0, 2'd0, 8'd0, 1'b0);
    chk(phase == p0 + 32'h1234_5677, "R4 new step next edge", phase, p0 + 32'h1234_5677);
    run(600);

    // R5: byte write and commit at the same edge
    load(32'h7FFF_FFFF);
    p0 = phase;
    tick(1'b1, 2'd3, 8'h00, 1'b1);
    tick(1'b0, 2'd0, 8'd0, 1'b0);
    chk(phase == p0 + 32'h1234_5677 + 32'h7FFF_FFFF, "R5 commit takes pre-write word",
        phase, p0 + 32'h1234_5677 + 32'h7FFF_FFFF);
    run(300);

    // R3: lane placement, step of 0x00FF_0003 from a new write pattern
    load(32'h00FF_0003);
    tick(1'b0, 2'd0, 8'd0, 1'b1);
    p0 = phase;
    tick(1'b0, 2'd0, 8'd0, 1'b0);
    chk(phase == p0 + 32'h00FF_0003, "R3 byte lanes", phase, p0 + 32'h00FF_0003);
    run(2000);

    // R2: wrap with step near full scale
    load(32'hFFFF_FFF0);
    tick(1'b0, 2'd0, 8'd0, 1'b1);
    run(200);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule